// File: doc/BRIEF.md
# Register-to-Register Operate Stage with Sign Flags

This block is the execute stage for the arithmetic and logic part of a 16-bit register machine. Each cycle it may take one instruction word. It decodes the word as an addition, a bitwise AND or a bitwise complement. It reads up to two operands from a private eight-entry register file. The second operand of ADD and AND comes either from a register or from a 5-bit immediate, which is sign-extended. The stage writes the result back into the destination register. It also latches a one-hot negative/zero/positive status that describes the value just written.

An instruction is offered with `op_valid` high. One clock edge later the result shows on `res_data`, together with `res_valid` and the destination index on `res_dest`. The register file is written on that same edge, so an instruction issued in the very next cycle already reads the new value. Words that are not well-formed operate instructions are dropped silently: no register changes, `res_valid` stays low and the flags hold.

Top module: `opu_core`

## Requirements
- R1: With opcode bits [15:12]=4'b0001 and bit [5]=0, the destination register [11:9] receives register[8:6] + register[2:0], taken modulo 2^16.
- R2: With opcode 4'b0101 and bit [5]=0, the destination receives the bitwise AND of register[8:6] and register[2:0].
- R3: When bit [5]=1 in an ADD or AND, the second operand is bits [4:0] sign-extended to 16 bits, so 5'b10000 means -16 and 5'b01111 means +15.
- R4: Opcode 4'b1001 with bits [5:0]=6'b111111 writes the complement of register[8:6] to the destination, and the source and destination may be the same register.
- R5: `res_dest` carries field [11:9] of the instruction that produced the current result.
- R6: The result appears on `res_data` with `res_valid` high exactly one cycle after the accepting edge. An instruction in the next cycle reads the updated register.
- R7: `flags` is {N,Z,P} in bits 2,1,0. Exactly one bit is set at all times, and it gives the sign of the last value written: bit 15 set, zero, or otherwise positive.
- R8: After reset all registers hold zero, `flags`=3'b010, `res_valid`=0 and `res_data`=0.
- R9: A word is ignored if `op_valid` is low, or if the opcode is anything other than the three above, or if an ADD/AND in register mode has bits [4:3] not equal to 2'b00, or if a NOT has bits [5:0] not all ones. An ignored word changes no register, raises no `res_valid` and leaves `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Instruction word is offered this cycle |
| op_word | input | 16 | Operate instruction word |
| res_valid | output | 1 | A register was written on the last edge |
| res_data | output | 16 | Value most recently written back |
| res_dest | output | 3 | Destination index of that write |
| flags | output | 3 | One-hot {N,Z,P} status |

## Verification
A behavioural model in the bench tracks every register and the flags, and is compared with the outputs on every cycle. Directed sequences build operands one immediate at a time. Each of register and immediate ADD/AND and NOT with a shared source/destination is then tried on values chosen so that a swapped operand, a zero-extended immediate or a wrong operation gives a different number. A doubling chain pushes 0x7FFF+1 to 0x8000, which separates a correct N flag from one derived from overflow or from the carry. Ignored forms are each followed by a read-out of their destination register through an ADD of zero, which exposes any stray write. A long run of mixed legal, malformed and idle cycles then stresses back-to-back dependencies.

// File: rtl/opu_pkg.sv
package opu_pkg;

   localparam int WORD_W = 16;
   localparam int IMM_W  = 5;
   localparam int SEL_W  = 3;

   localparam int FLAG_N = 2;
   localparam int FLAG_Z = 1;
   localparam int FLAG_P = 0;

   typedef enum logic [3:0] {
      OPC_ADD = 4'b0001,
      OPC_AND = 4'b0101,
      OPC_NOT = 4'b1001
   } opcode_e;

   typedef enum logic [1:0] {
      FN_ADD = 2'd0,
      FN_AND = 2'd1,
      FN_NOT = 2'd2
   } alu_fn_e;

   typedef struct packed {
      logic             legal;
      alu_fn_e          fn;
      logic             use_imm;
      logic [SEL_W-1:0] rd;
      logic [SEL_W-1:0] rs1;
      logic [SEL_W-1:0] rs2;
      logic [IMM_W-1:0] imm;
   } dec_t;

endpackage

// File: rtl/opu_decode.sv
module opu_decode
   import opu_pkg::*;
#(
   parameter int REG_CNT = 8
) (
   input  logic [WORD_W-1:0] word,
   output dec_t              dec
);

   logic shape_ok;
   logic in_range;
   logic rs2_used;

   always_comb begin
      dec         = '0;
      shape_ok    = 1'b0;
      dec.rd      = word[11:9];
      dec.rs1     = word[8:6];
      dec.rs2     = word[2:0];
      dec.imm     = word[4:0];
      dec.use_imm = word[5];
      unique case (word[15:12])
         OPC_ADD: begin
            dec.fn   = FN_ADD;
            shape_ok = word[5] | (word[4:3] == 2'b00);
         end
         OPC_AND: begin
            dec.fn   = FN_AND;
            shape_ok = word[5] | (word[4:3] == 2'b00);
         end
         OPC_NOT: begin
            dec.fn      = FN_NOT;
            dec.use_imm = 1'b0;
            shape_ok    = &word[5:0];
         end
         default: shape_ok = 1'b0;
      endcase
      dec.legal = shape_ok & in_range;
   end

   assign rs2_used = ~word[5] & (word[15:12] != OPC_NOT);

   generate
      if (REG_CNT == (1 << SEL_W)) begin : g_full_file
         assign in_range = 1'b1;
      end else begin : g_short_file
         localparam logic [SEL_W:0] LIMIT = REG_CNT[SEL_W:0];
         assign in_range = ({1'b0, word[11:9]} < LIMIT) &&
                           ({1'b0, word[8:6]}  < LIMIT) &&
                           (!rs2_used || ({1'b0, word[2:0]} < LIMIT));
      end
   endgenerate

endmodule

// File: rtl/opu_regfile.sv
module opu_regfile #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 8,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_sel,
   input  logic [DATA_W-1:0] wr_val,
   input  logic [AW-1:0]     rd_sel_a,
   input  logic [AW-1:0]     rd_sel_b,
   output logic [DATA_W-1:0] rd_val_a,
   output logic [DATA_W-1:0] rd_val_b
);

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
      end else if (wr_en) begin
         cells[wr_sel] <= wr_val;
      end
   end

   assign rd_val_a = cells[rd_sel_a];
   assign rd_val_b = cells[rd_sel_b];

endmodule

// File: rtl/opu_alu.sv
module opu_alu
   import opu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_fn_e           fn,
   input  logic              use_imm,
   input  logic [IMM_W-1:0]  imm,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] result,
   output logic [2:0]        nzp
);

   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] opnd_b;

   assign opnd_b = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : src_b;

   always_comb begin
      unique case (fn)
         FN_ADD:  result = src_a + opnd_b;
         FN_AND:  result = src_a & opnd_b;
         FN_NOT:  result = ~src_a;
         default: result = '0;
      endcase
   end

   always_comb begin
      nzp         = '0;
      nzp[FLAG_N] = result[DATA_W-1];
      nzp[FLAG_Z] = (result == '0);
      nzp[FLAG_P] = ~result[DATA_W-1] & (result != '0);
   end

endmodule

// File: rtl/opu_core.sv
module opu_core
   import opu_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int REG_CNT = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [15:0]       op_word,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [2:0]        res_dest,
   output logic [2:0]        flags
);

   localparam int AW = $clog2(REG_CNT);
   localparam logic [2:0] FLAGS_RST = 3'b010;

   generate
      if (DATA_W < IMM_W + 1) begin : g_bad_width
         $error("DATA_W must exceed the immediate width");
      end
      if (REG_CNT < 2 || REG_CNT > (1 << SEL_W) ||
          (REG_CNT & (REG_CNT - 1)) != 0) begin : g_bad_depth
         $error("REG_CNT must be a power of two between 2 and 8");
      end
   endgenerate

   dec_t              dec;
   logic              wr_go;
   logic [DATA_W-1:0] val_a;
   logic [DATA_W-1:0] val_b;
   logic [DATA_W-1:0] alu_out;
   logic [2:0]        alu_nzp;

   opu_decode #(.REG_CNT(REG_CNT)) u_decode (
      .word (op_word),
      .dec  (dec)
   );

   assign wr_go = op_valid & dec.legal;

   opu_regfile #(.DATA_W(DATA_W), .DEPTH(REG_CNT)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_go),
      .wr_sel   (dec.rd[AW-1:0]),
      .wr_val   (alu_out),
      .rd_sel_a (dec.rs1[AW-1:0]),
      .rd_sel_b (dec.rs2[AW-1:0]),
      .rd_val_a (val_a),
      .rd_val_b (val_b)
   );

   opu_alu #(.DATA_W(DATA_W)) u_alu (
      .fn      (dec.fn),
      .use_imm (dec.use_imm),
      .imm     (dec.imm),
      .src_a   (val_a),
      .src_b   (val_b),
      .result  (alu_out),
      .nzp     (alu_nzp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_data  <= '0;
         res_dest  <= '0;
         flags     <= FLAGS_RST;
      end else begin
         res_valid <= wr_go;
         if (wr_go) begin
            res_data <= alu_out;
            res_dest <= dec.rd;
            flags    <= alu_nzp;
         end
      end
   end

   // R7
   flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(flags) == 1);

   // R9
   idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> !res_valid);

   // R7
   flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> $stable(flags));

   // R7
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (flags[FLAG_Z] == (res_data == '0)));

   // R5
   dest_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_go |=> (res_dest == $past(op_word[11:9])));

endmodule

// File: tb/opu_core_test.sv
module opu_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [15:0] op_word = '0;
   logic        res_valid;
   logic [15:0] res_data;
   logic [2:0]  res_dest;
   logic [2:0]  flags;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [15:0] m_reg [8];
   logic        m_valid;
   logic [15:0] m_data;
   logic [2:0]  m_dest;
   logic [2:0]  m_flags;

   always #10 clk = ~clk;

   opu_core uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_word   (op_word),
      .res_valid (res_valid),
      .res_data  (res_data),
      .res_dest  (res_dest),
      .flags     (flags)
   );

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic bit is_legal(logic [15:0] w);
      case (w[15:12])
         4'b0001, 4'b0101: return w[5] || (w[4:3] == 2'b00);
         4'b1001:          return (w[5:0] == 6'h3F);
         default:          return 1'b0;
      endcase
   endfunction

   function automatic logic [15:0] enc_r(logic [3:0] op, int rd, int ra, int rb);
      return {op, 3'(rd), 3'(ra), 1'b0, 2'b00, 3'(rb)};
   endfunction

   function automatic logic [15:0] enc_i(logic [3:0] op, int rd, int ra, int imm);
      return {op, 3'(rd), 3'(ra), 1'b1, 5'(imm)};
   endfunction

   function automatic logic [15:0] enc_n(int rd, int ra);
      return {4'b1001, 3'(rd), 3'(ra), 6'h3F};
   endfunction

   // drive at a falling edge, compare at the next falling edge
   task automatic step(logic v, logic [15:0] w, string tag);
      logic [15:0] a, b, r;
      op_valid = v;
      op_word  = w;
      m_valid  = v && is_legal(w);
      if (m_valid) begin
         a = m_reg[w[8:6]];
         b = w[5] ? {{11{w[4]}}, w[4:0]} : m_reg[w[2:0]];
         case (w[15:12])
            4'b0001: r = a + b;
            4'b0101: r = a & b;
            default: r = ~a;
         endcase
         m_reg[w[11:9]] = r;
         m_data  = r;
         m_dest  = w[11:9];
         m_flags = r[15] ? 3'b100 : ((r == 16'h0) ? 3'b010 : 3'b001);
      end
      @(negedge clk);
      chk(tag, "res_valid", {15'h0, res_valid}, {15'h0, m_valid});
      chk(tag, "res_data", res_data, m_data);
      chk("R5", "res_dest", {13'h0, res_dest}, {13'h0, m_dest});
      chk("R7", "flags", {13'h0, flags}, {13'h0, m_flags});
   endtask

   task automatic load(int rd, int imm);
      step(1'b1, enc_i(4'b0101, rd, rd, 0), "R3");
      step(1'b1, enc_i(4'b0001, rd, rd, imm), "R3");
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) m_reg[i] = 16'h0;
      m_valid = 1'b0;
      m_data  = 16'h0;
      m_dest  = 3'h0;
      m_flags = 3'b010;

      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8", "res_valid", {15'h0, res_valid}, 16'h0);
      chk("R8", "res_data", res_data, 16'h0);
      chk("R8", "flags", {13'h0, flags}, 16'h0002);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 8; i++) step(1'b1, enc_i(4'b0001, i, i, 0), "R8");

      // R3 immediates at both ends of the range
      load(1, 5);
      load(2, -3);
      load(6, -16);
      load(7, 15);
      // R1 register ADD, R2 register AND
      step(1'b1, enc_r(4'b0001, 3, 1, 2), "R1");
      step(1'b1, enc_r(4'b0001, 0, 6, 7), "R1");
      step(1'b1, enc_r(4'b0101, 4, 1, 2), "R2");
      step(1'b1, enc_r(4'b0101, 5, 6, 7), "R2");
      step(1'b1, enc_i(4'b0101, 5, 2, -8), "R3");
      // R4 complement in place
      step(1'b1, enc_n(1, 1), "R4");
      step(1'b1, enc_n(4, 3), "R4");
      // R6 dependent back-to-back chain
      step(1'b1, enc_r(4'b0001, 5, 3, 3), "R6");
      step(1'b1, enc_r(4'b0001, 5, 5, 5), "R6");
      step(1'b1, enc_r(4'b0101, 5, 5, 7), "R6");

      // R1 / R7 signed wrap 0x7FFF + 1
      load(0, 1);
      for (int i = 0; i < 15; i++) step(1'b1, enc_r(4'b0001, 0, 0, 0), "R1");
      step(1'b1, enc_n(0, 0), "R4");
      step(1'b1, enc_i(4'b0001, 0, 0, 1), "R1");

      // R9 ignored forms, each followed by a read-out of its destination
      step(1'b1, {4'b0010, 3'd2, 3'd1, 6'h01}, "R9");
      step(1'b1, enc_i(4'b0001, 2, 2, 0), "R9");
      step(1'b1, {4'b0001, 3'd3, 3'd1, 1'b0, 2'b01, 3'd2}, "R9");
      step(1'b1, enc_i(4'b0001, 3, 3, 0), "R9");
      step(1'b1, {4'b0101, 3'd3, 3'd1, 1'b0, 2'b10, 3'd2}, "R9");
      step(1'b1, enc_i(4'b0001, 3, 3, 0), "R9");
      step(1'b1, {4'b1001, 3'd4, 3'd4, 6'h3E}, "R9");
      step(1'b1, enc_i(4'b0001, 4, 4, 0), "R9");
      step(1'b0, enc_n(6, 6), "R9");
      step(1'b0, enc_r(4'b0001, 6, 6, 6), "R9");
      step(1'b1, enc_i(4'b0001, 6, 6, 0), "R9");

      // mixed stream
      for (int n = 0; n < 600; n++) begin
         int sel;
         logic [15:0] w;
         string tag;
         sel = int'($urandom_range(0, 9));
         w = 16'($urandom);
         case (sel)
            0, 1: w = enc_r(4'b0001, w[11:9], w[8:6], w[2:0]);
            2, 3: w = enc_r(4'b0101, w[11:9], w[8:6], w[2:0]);
            4, 5: w = enc_i(($urandom_range(0, 1) != 0) ? 4'b0001 : 4'b0101,
                            w[11:9], w[8:6], w[4:0]);
            6:    w = enc_n(w[11:9], w[8:6]);
            default: ;
         endcase
         if (!is_legal(w) || sel == 9) tag = "R9";
         else if (w[15:12] == 4'b1001) tag = "R4";
         else if (w[5]) tag = "R3";
         else if (w[15:12] == 4'b0001) tag = "R1";
         else tag = "R2";
         step(sel != 9, w, tag);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule